// File: doc/BRIEF.md
# Vertical Acquisition Line Timer

This block times the incoming video fields in whole lines. A per-line enable pulse moves a 9-bit line counter forward. The counter does not move on other clocks. A rising edge on the field sync input ends the current field. At that edge the block captures the field's length in lines and restarts the count at line 0. A separate reference pulse captures the current line number, which gives the number of lines between the field sync and that reference. A double-rate display timer downstream uses these two figures to correct its own vertical sync.

From the same line count the block also drives two outputs. The first is a write-reset pulse for the field memory, which covers line 0 of every field. The second is a write window whose first and end lines come from two 9-bit settings, with a resolution of one line. A field flag toggles on every field. An overflow flag reports a field that ran past the largest count the counter can hold.

Top module: `vacq_timer`

## Requirements
- R1: The line number (`line_no`) rises by one at each clock edge where `line_en` is high and holds its value at every other edge, unless R2 or R3 applies.
- R2: A field edge is a clock where `fsync` is high and was low at the previous clock. At a field edge, `field_len` takes the line number as it stood before the edge and the line number returns to 0. This holds even when `line_en` is high in the same cycle. Holding `fsync` high for several clocks produces only one field edge.
- R3: When `line_en` arrives while the line number is 511, the line number stays at 511 and `overflow` goes high. `overflow` stays high until the next field edge clears it, and the value captured into `field_len` at that edge is 511.
- R4: At each clock edge where `ref_pulse` is high, `sync_offset` takes the line number as it stood before the edge. If that edge is also a field edge, `sync_offset` takes 0.
- R5: `wr_reset` is high exactly while the line number is 0, once at least one field edge has occurred since reset.
- R6: `wr_window` is high while `win_start` <= line number < `win_stop` (both 9-bit, unsigned, in lines), once at least one field edge has occurred. If `win_start` >= `win_stop`, `wr_window` stays low.
- R7: `field_id` starts at 0 and inverts at every field edge.
- R8: After reset, `line_no`, `field_len`, `sync_offset`, `field_id`, `overflow`, `wr_reset` and `wr_window` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_en | input | 1 | One-clock pulse for each line |
| fsync | input | 1 | Incoming field sync, acts on its rising edge |
| ref_pulse | input | 1 | Line reference used to measure the sync offset |
| win_start | input | 9 | First line of the write window |
| win_stop | input | 9 | First line after the write window |
| line_no | output | 9 | Current line number in the field |
| field_len | output | 9 | Length of the last complete field in lines |
| sync_offset | output | 9 | Lines from the field edge to the last reference pulse |
| wr_reset | output | 1 | Memory write-reset pulse covering line 0 |
| wr_window | output | 1 | Vertical write window enable |
| field_id | output | 1 | Field flag, toggles every field |
| overflow | output | 1 | Field ran past line 511 |

## Verification
Properties inside the RTL check the counter on every cycle: it steps, holds, saturates and clears as required. The same properties check the captures of the field length and the offset, the field flag toggle, and that the reset pulse appears only on line 0. Several things can only be shown by the bench's scenarios. One is that a held sync does not retrigger. Another is that a sync in the same cycle as a line pulse wins. The bench also checks the exact lines where the window opens and closes, the empty-window settings, and the values read at the ports after an overflowing field.

// File: rtl/vacq_pkg.sv
package vacq_pkg;

  // Half-open line interval test used by the write window.
  function automatic logic in_window(input int unsigned line,
                                     input int unsigned first,
                                     input int unsigned last);
    return (line >= first) && (line < last);
  endfunction

  // True when a count of the given width is at its largest value.
  function automatic logic at_limit(input int unsigned cnt,
                                    input int unsigned width);
    return cnt == ((32'd1 << width) - 32'd1);
  endfunction

endpackage

// File: rtl/vacq_line_counter.sv
module vacq_line_counter #(
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_en,
  input  logic              field_edge,
  output logic [LINE_W-1:0] line_cnt,
  output logic              ovf
);
  import vacq_pkg::*;

  logic full;
  assign full = at_limit(32'(line_cnt), LINE_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= '0;
      ovf      <= 1'b0;
    end else if (field_edge) begin
      line_cnt <= '0;
      ovf      <= 1'b0;
    end else if (line_en) begin
      if (full) ovf <= 1'b1;
      else      line_cnt <= line_cnt + 1'b1;
    end
  end

  // R1: step and hold
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    line_en && !field_edge && !full |=> line_cnt == $past(line_cnt) + 1'b1);
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en && !field_edge |=> $stable(line_cnt));
  // R3: saturation
  a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    line_en && !field_edge && full |=> full && ovf);
  // R2: clear on field edge
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    field_edge |=> line_cnt == '0 && !ovf);
endmodule

// File: rtl/vacq_field_meas.sv
module vacq_field_meas #(
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              ref_pulse,
  input  logic [LINE_W-1:0] line_cnt,
  output logic              field_edge,
  output logic [LINE_W-1:0] field_len,
  output logic [LINE_W-1:0] offset,
  output logic              field_id,
  output logic              locked
);
  logic fsync_q;

  assign field_edge = fsync && !fsync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsync_q   <= 1'b0;
      field_len <= '0;
      offset    <= '0;
      field_id  <= 1'b0;
      locked    <= 1'b0;
    end else begin
      fsync_q <= fsync;
      if (field_edge) begin
        field_len <= line_cnt;
        field_id  <= ~field_id;
        locked    <= 1'b1;
      end
      if (ref_pulse) offset <= field_edge ? '0 : line_cnt;
    end
  end

  // R7: flag inverts per field
  a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    field_edge |=> field_id != $past(field_id));
  // R2: length capture and no retrigger on a held sync
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    field_edge |=> field_len == $past(line_cnt));
  a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
    field_edge |=> !field_edge);
  // R4: offset capture
  a_r4_offset: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse && !field_edge |=> offset == $past(line_cnt));
endmodule

// File: rtl/vacq_window.sv
module vacq_window #(
  parameter int LINE_W = 9
) (
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              locked,
  input  logic [LINE_W-1:0] win_start,
  input  logic [LINE_W-1:0] win_stop,
  output logic              wr_reset,
  output logic              wr_window
);
  import vacq_pkg::*;

  assign wr_reset  = locked && (line_cnt == '0);
  assign wr_window = locked &&
                     in_window(32'(line_cnt), 32'(win_start), 32'(win_stop));
endmodule

// File: rtl/vacq_timer.sv
module vacq_timer #(
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_en,
  input  logic              fsync,
  input  logic              ref_pulse,
  input  logic [LINE_W-1:0] win_start,
  input  logic [LINE_W-1:0] win_stop,
  output logic [LINE_W-1:0] line_no,
  output logic [LINE_W-1:0] field_len,
  output logic [LINE_W-1:0] sync_offset,
  output logic              wr_reset,
  output logic              wr_window,
  output logic              field_id,
  output logic              overflow
);
  logic field_edge;
  logic locked;

  vacq_field_meas #(.LINE_W(LINE_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .ref_pulse(ref_pulse),
    .line_cnt(line_no), .field_edge(field_edge), .field_len(field_len),
    .offset(sync_offset), .field_id(field_id), .locked(locked)
  );

  vacq_line_counter #(.LINE_W(LINE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .field_edge(field_edge),
    .line_cnt(line_no), .ovf(overflow)
  );

  vacq_window #(.LINE_W(LINE_W)) u_win (
    .line_cnt(line_no), .locked(locked), .win_start(win_start),
    .win_stop(win_stop), .wr_reset(wr_reset), .wr_window(wr_window)
  );

  // R5: reset pulse follows a field edge and never leaves line 0
  a_r5_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    field_edge |=> wr_reset);
  a_r5_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reset && line_en && !field_edge |=> !wr_reset);
  // R6: an empty setting keeps the window shut
  a_r6_empty: assert property (@(posedge clk) disable iff (!rst_n)
    win_start >= win_stop |-> !wr_window);
endmodule

// File: tb/vacq_timer_bench.sv
module vacq_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_en = 1'b0;
  logic       fsync = 1'b0;
  logic       ref_pulse = 1'b0;
  logic [8:0] win_start = 9'd0;
  logic [8:0] win_stop = 9'd0;
  logic [8:0] line_no, field_len, sync_offset;
  logic       wr_reset, wr_window, field_id, overflow;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  vacq_timer u_vacq_timer (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .fsync(fsync),
    .ref_pulse(ref_pulse), .win_start(win_start), .win_stop(win_stop),
    .line_no(line_no), .field_len(field_len), .sync_offset(sync_offset),
    .wr_reset(wr_reset), .wr_window(wr_window), .field_id(field_id),
    .overflow(overflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock with the given inputs; returns 1 ns after the edge
  task automatic cyc(input logic le, input logic fs, input logic rp);
    line_en = le; fsync = fs; ref_pulse = rp;
    @(posedge clk); #1;
  endtask

  task automatic lines(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    chk("R8 line_no", int'(line_no), 0);
    chk("R8 field_len", int'(field_len), 0);
    chk("R8 sync_offset", int'(sync_offset), 0);
    chk("R8 field_id", int'(field_id), 0);
    chk("R8 overflow", int'(overflow), 0);
    chk("R8 wr_reset", int'(wr_reset), 0);
    chk("R8 wr_window", int'(wr_window), 0);
  endtask

  task automatic t_first_field;
    cyc(1'b0, 1'b1, 1'b0);
    chk("R2 line cleared", int'(line_no), 0);
    chk("R5 pulse on line 0", int'(wr_reset), 1);
    chk("R7 first toggle", int'(field_id), 1);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0);
    chk("R2 held sync no retrigger", int'(line_no), 3);
    chk("R7 no toggle on held sync", int'(field_id), 1);
    chk("R5 pulse gone", int'(wr_reset), 0);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0);
    chk("R1 hold without line_en", int'(line_no), 3);
  endtask

  task automatic t_offset;
    lines(4);
    chk("R1 count", int'(line_no), 7);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R4 offset", int'(sync_offset), 7);
    cyc(1'b1, 1'b0, 1'b1);
    chk("R4 offset pre-step value", int'(sync_offset), 7);
    chk("R1 step with ref", int'(line_no), 8);
  endtask

  task automatic t_length;
    lines(292);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R2 field length", int'(field_len), 300);
    chk("R7 second toggle", int'(field_id), 0);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R1 new field", int'(line_no), 1);
  endtask

  task automatic t_priority;
    lines(9);
    cyc(1'b1, 1'b1, 1'b1);
    chk("R2 sync beats line_en", int'(line_no), 0);
    chk("R2 length", int'(field_len), 10);
    chk("R4 offset zero on edge", int'(sync_offset), 0);
    cyc(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_window;
    win_start = 9'd10; win_stop = 9'd20;
    lines(9);
    chk("R6 before start", int'(wr_window), 0);
    lines(1);
    chk("R6 at start", int'(wr_window), 1);
    lines(9);
    chk("R6 last line", int'(wr_window), 1);
    lines(1);
    chk("R6 at stop", int'(wr_window), 0);
    win_start = 9'd30; win_stop = 9'd30;
    lines(10);
    chk("R6 equal bounds", int'(wr_window), 0);
    win_start = 9'd40; win_stop = 9'd35;
    lines(7);
    chk("R6 reversed bounds", int'(wr_window), 0);
  endtask

  task automatic t_overflow;
    cyc(1'b0, 1'b1, 1'b0);
    lines(511);
    chk("R3 at 511", int'(line_no), 511);
    chk("R3 not yet overflow", int'(overflow), 0);
    lines(1);
    chk("R3 saturated", int'(line_no), 511);
    chk("R3 overflow set", int'(overflow), 1);
    lines(50);
    chk("R3 still saturated", int'(line_no), 511);
    cyc(1'b0, 1'b1, 1'b0);
    chk("R3 length at limit", int'(field_len), 511);
    chk("R3 overflow cleared", int'(overflow), 0);
    chk("R5 pulse after overflow", int'(wr_reset), 1);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0);
    t_reset;
    t_first_field;
    t_idle;
    t_offset;
    t_length;
    t_priority;
    t_window;
    t_overflow;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule